// File: doc/BRIEF.md
# Keyed Logical-Device Configuration Controller

This block holds the configuration state of a multi-function I/O controller. Software reaches it through two byte ports: an index port that selects a register and a data port that reads or writes that register. After reset the block is sealed. Two back-to-back key bytes on the index port open it, and a distinct exit byte seals it again. Indices below 0x30 reach a flat set of global registers. Global register 7 picks which logical device's bank appears at indices 0x30 and above.

Four of the devices consume a base address, an enable bit and an interrupt line: the floppy controller (device 0), the parallel port (device 3) and two serial ports (devices 4 and 5). A programmed base is not trusted. One clock after it is written, the block masks it, tests it against that device's list of legal bases, replaces an illegal value with the device default, and writes the result back into the bank. Downstream logic decodes the per-device outputs directly, so an active device's decoder never settles on an illegal base.

Top module: `lcfg_ctl`

## Requirements
- R1: After reset the block is sealed. Global registers 0x03, 0x20, 0x21, 0x24, 0x26 and 0x27 hold 0x03, 0x03, 0x01, 0x04, 0xF0 and 0x03, and every other global register holds 0x00. The device outputs are: bases 0x3F0, 0x378, 0x3F8 and 0x2F8 for output slots 0..3 (devices 0, 3, 4, 5), all four enabled, and interrupt numbers 6, 7, 4 and 3.
- R2: While the block is sealed, it opens only after two consecutive 0x55 writes to the index port (bus_addr=0). Any other index byte restarts the count. Data-port writes (bus_addr=1) made while sealed change nothing.
- R3: While sealed, both ports read 0xFF.
- R4: While open, an index write of 0xAA seals the block. Any other index write loads the register pointer, and the index port reads the pointer back.
- R5: While open, a data access with a pointer below 0x30 reads or writes global register [pointer], for all 48 global registers.
- R6: A data access with a pointer of 0x30 or above goes to the bank of the device numbered by global register 7. The bank implements 0x30, 0x60 to 0x63, 0x70, 0x74 and 0xF0 to 0xF7. Other bank indices read 0x00 and ignore writes. A device number of 10 or more reads 0xFF.
- R7: Writes to bank indices 0x70 to 0x7F are ignored for devices 0 to 3. All bank writes are ignored for devices 6 and above.
- R8: Writing bank index 0x60 or 0x61 of an enabled managed device starts a base check on the next clock edge. The check forms base = ({0x60[3:0],0x61}) & 0xFF8. If the base lies outside 0x100 to 0xFF8 or is not on the device's legal list, the default replaces it. The result is written back as 0x60 = base[11:8] and 0x61 = base[7:0].
- R9: Legal bases are: device 0 {0x3F0, 0x370}, default 0x3F0; device 3 {0x3BC, 0x378, 0x278}, default 0x378; devices 4 and 5 {0x3F8, 0x2F8, 0x338, 0x3E8, 0x2E8, 0x220, 0x238, 0x2E0, 0x228}, defaults 0x3F8 and 0x2F8. Because the mask clears bits 2:0, 0x3BC can never pass and falls back to 0x378.
- R10: Bit 0 of bank index 0x30 enables a device. Base writes to a disabled device are stored unchecked. Writing 0x30 with bit 0 set starts the same base check as R8.
- R11: For each output slot m, base = {0x60[3:0],0x61} of its bank, enable = 0x30[0], and interrupt number = 0x70[3:0]. A plain write shows on these outputs right after the clock edge that stores it. A corrected base shows one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte of the selected port (combinational) |
| dev_base_o | output | 48 | Four 12-bit bases; slot m occupies bits [12m+11:12m] |
| dev_act_o | output | 4 | Enable bit per slot |
| dev_irq_o | output | 16 | Four 4-bit interrupt numbers |

## Verification
The base check is driven with legal values, with values that are legal only once bits 2:0 are cleared, with values whose upper byte carries stray high bits, with values that are well formed but absent from the list, and with the 0x3BC entry that the mask makes unreachable. Together these separate a correct mask from a missing mask, a missing write-back and a list mix-up between devices. The output is sampled both at the edge that stores the raw value and at the edge that stores the correction, which pins down the one-cycle delay. A disabled device written with an illegal base and then enabled shows whether the enable write starts the check. Key sequences broken by a stray byte tell a two-in-a-row counter apart from a plain counter.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;

   localparam int NUM_MGD  = 4;
   localparam int NUM_SLOT = 15;
   localparam int SLOT_W   = 4;
   localparam int BASE_W   = 12;
   localparam int IRQ_W    = 4;

   localparam int SLOT_ACT = 0;
   localparam int SLOT_BHI = 1;
   localparam int SLOT_BLO = 2;
   localparam int SLOT_IRQ = 5;

   localparam logic [11:0] BASE_MASK = 12'hFF8;
   localparam logic [11:0] BASE_MIN  = 12'h100;
   localparam logic [11:0] BASE_MAX  = 12'hFF8;

   // device number behind each managed output slot
   function automatic int mgd_dev(input int m);
      case (m)
         0: return 0;
         1: return 3;
         2: return 4;
         default: return 5;
      endcase
   endfunction

   function automatic logic [11:0] mgd_default(input int m);
      case (m)
         0: return 12'h3F0;
         1: return 12'h378;
         2: return 12'h3F8;
         default: return 12'h2F8;
      endcase
   endfunction

   function automatic logic serial_ok(input logic [11:0] p);
      return (p == 12'h3F8) || (p == 12'h2F8) || (p == 12'h338) ||
             (p == 12'h3E8) || (p == 12'h2E8) || (p == 12'h220) ||
             (p == 12'h238) || (p == 12'h2E0) || (p == 12'h228);
   endfunction

   function automatic logic base_ok(input int m, input logic [11:0] p);
      case (m)
         0: return (p == 12'h3F0) || (p == 12'h370);
         1: return (p == 12'h3BC) || (p == 12'h378) || (p == 12'h278);
         default: return serial_ok(p);
      endcase
   endfunction

   function automatic logic slot_hit(input logic [7:0] idx);
      return (idx == 8'h30) || (idx[7:2] == 6'b011000) ||
             (idx == 8'h70) || (idx == 8'h74) || (idx[7:3] == 5'b11110);
   endfunction

   function automatic logic [SLOT_W-1:0] slot_of(input logic [7:0] idx);
      case (idx)
         8'h30: return 4'd0;
         8'h60: return 4'd1;
         8'h61: return 4'd2;
         8'h62: return 4'd3;
         8'h63: return 4'd4;
         8'h70: return 4'd5;
         8'h74: return 4'd6;
         default: return (idx[7:3] == 5'b11110) ? 4'd7 + {1'b0, idx[2:0]} : 4'd0;
      endcase
   endfunction

   function automatic logic [7:0] bank_reset(input int dev, input int slot);
      logic [7:0] r;
      r = 8'h00;
      case (dev)
         0: case (slot)
               0: r = 8'h01;  1: r = 8'h03;  2: r = 8'hF0;  5: r = 8'h06;
               6: r = 8'h02;  7: r = 8'h0E;  9: r = 8'hFF;  default: r = 8'h00;
            endcase
         1: case (slot)
               1: r = 8'h01;  2: r = 8'hF0;  3: r = 8'h03;  4: r = 8'hF6;
               5: r = 8'h0E;  7: r = 8'h0C;  default: r = 8'h00;
            endcase
         2: case (slot)
               1: r = 8'h01;  2: r = 8'h70;  3: r = 8'h03;  4: r = 8'h76;
               5: r = 8'h0F;  default: r = 8'h00;
            endcase
         3: case (slot)
               0: r = 8'h01;  1: r = 8'h03;  2: r = 8'h78;  5: r = 8'h07;
               6: r = 8'h04;  7: r = 8'h3C;  default: r = 8'h00;
            endcase
         4: case (slot)
               0: r = 8'h01;  1: r = 8'h03;  2: r = 8'hF8;  5: r = 8'h04;
               7: r = 8'h03;  default: r = 8'h00;
            endcase
         5: case (slot)
               0: r = 8'h01;  1: r = 8'h02;  2: r = 8'hF8;  5: r = 8'h03;
               6: r = 8'h04;  8: r = 8'h02;  9: r = 8'h03;  default: r = 8'h00;
            endcase
         6: case (slot)
               4: r = 8'h70;  11: r = 8'h03;  default: r = 8'h00;
            endcase
         7: case (slot)
               0: r = 8'h01;  2: r = 8'h60;  5: r = 8'h01;  default: r = 8'h00;
            endcase
         default: r = 8'h00;
      endcase
      return r;
   endfunction

   function automatic logic [7:0] glob_reset(input int idx);
      case (idx)
         8'h03: return 8'h03;
         8'h20: return 8'h03;
         8'h21: return 8'h01;
         8'h24: return 8'h04;
         8'h26: return 8'hF0;
         8'h27: return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/lcfg_gate.sv
module lcfg_gate #(
   parameter logic [7:0] KEY_BYTE  = 8'h55,
   parameter logic [7:0] EXIT_BYTE = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open_o,
   output logic [7:0] ptr_o
);

   logic key_half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_o     <= 1'b0;
         key_half_q <= 1'b0;
         ptr_o      <= 8'h00;
      end else if (idx_wr) begin
         if (!open_o) begin
            if (wdata == KEY_BYTE) begin
               if (key_half_q) begin
                  open_o     <= 1'b1;
                  key_half_q <= 1'b0;
               end else begin
                  key_half_q <= 1'b1;
               end
            end else begin
               key_half_q <= 1'b0;
            end
         end else if (wdata == EXIT_BYTE) begin
            open_o <= 1'b0;
         end else begin
            ptr_o <= wdata;
         end
      end
   end

endmodule

// File: rtl/lcfg_base_fix.sv
module lcfg_base_fix
   import lcfg_pkg::*;
#(
   parameter int SEL = 0
) (
   input  logic [3:0]        hi_i,
   input  logic [7:0]        lo_i,
   output logic [BASE_W-1:0] base_o
);

   logic [BASE_W-1:0] masked;
   logic              in_range;

   always_comb begin
      masked   = {hi_i, lo_i} & BASE_MASK;
      in_range = (masked >= BASE_MIN) && (masked <= BASE_MAX);
      base_o   = (in_range && base_ok(SEL, masked)) ? masked : mgd_default(SEL);
   end

endmodule

// File: rtl/lcfg_store.sv
module lcfg_store
   import lcfg_pkg::*;
#(
   parameter int NUM_DEV      = 10,
   parameter int NUM_GLOBAL   = 48,
   parameter int BANK_IDX     = 8'h30,
   parameter int SEL_REG      = 7,
   parameter int WR_LAST_DEV  = 5,
   parameter int IRQ_FREE_DEV = 4,
   parameter bit CHECK_ON_ACT = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               data_wr,
   input  logic [7:0]                         wdata,
   input  logic [7:0]                         ptr,
   input  logic [NUM_MGD-1:0][BASE_W-1:0]     fix_i,
   output logic [7:0]                         rdata,
   output logic [NUM_MGD-1:0]                 pend_o,
   output logic [NUM_MGD-1:0][3:0]            raw_hi_o,
   output logic [NUM_MGD-1:0][7:0]            raw_lo_o,
   output logic [NUM_MGD-1:0]                 act_o,
   output logic [NUM_MGD-1:0][IRQ_W-1:0]      irq_o
);

   localparam int DEV_W  = $clog2(NUM_DEV);
   localparam int GIDX_W = $clog2(NUM_GLOBAL);

   logic [7:0]          glob_q [NUM_GLOBAL];
   logic [7:0]          bank_q [NUM_DEV][NUM_SLOT];
   logic [NUM_MGD-1:0]  pend_q;
   logic [NUM_MGD-1:0]  trig;

   logic [7:0]          dev_sel;
   logic [DEV_W-1:0]    dev_i;
   logic                dev_ok;
   logic                in_bank;
   logic                hit;
   logic [SLOT_W-1:0]   slot;
   logic                g_ok;
   logic [GIDX_W-1:0]   gidx;
   logic                irq_win;
   logic                bank_we;
   logic                glob_we;

   assign dev_sel = glob_q[SEL_REG];
   assign dev_i   = dev_sel[DEV_W-1:0];
   assign dev_ok  = dev_sel < 8'(NUM_DEV);
   assign in_bank = ptr >= 8'(BANK_IDX);
   assign hit     = slot_hit(ptr);
   assign slot    = slot_of(ptr);
   assign g_ok    = ptr < 8'(NUM_GLOBAL);
   assign gidx    = ptr[GIDX_W-1:0];
   assign irq_win = ptr[7:4] == 4'h7;

   assign bank_we = data_wr && in_bank && hit && dev_ok &&
                    (dev_sel <= 8'(WR_LAST_DEV)) &&
                    !(irq_win && (dev_sel < 8'(IRQ_FREE_DEV)));
   assign glob_we = data_wr && !in_bank && g_ok;

   // trigger logic and output taps, one copy per managed device
   for (genvar m = 0; m < NUM_MGD; m++) begin : g_mgd
      localparam int DEV = mgd_dev(m);
      logic sel_me;
      logic base_hit;
      logic act_hit;

      assign sel_me   = bank_we && (dev_sel == 8'(DEV));
      assign base_hit = sel_me && ((slot == 4'(SLOT_BHI)) || (slot == 4'(SLOT_BLO))) &&
                        bank_q[DEV][SLOT_ACT][0];

      if (CHECK_ON_ACT) begin : g_act_chk
         assign act_hit = sel_me && (slot == 4'(SLOT_ACT)) && wdata[0];
      end else begin : g_act_none
         assign act_hit = 1'b0;
      end

      assign trig[m]     = base_hit || act_hit;
      assign act_o[m]    = bank_q[DEV][SLOT_ACT][0];
      assign raw_hi_o[m] = bank_q[DEV][SLOT_BHI][3:0];
      assign raw_lo_o[m] = bank_q[DEV][SLOT_BLO];
      assign irq_o[m]    = bank_q[DEV][SLOT_IRQ][IRQ_W-1:0];
   end

   assign pend_o = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         for (int g = 0; g < NUM_GLOBAL; g++) glob_q[g] <= glob_reset(g);
         for (int d = 0; d < NUM_DEV; d++)
            for (int s = 0; s < NUM_SLOT; s++) bank_q[d][s] <= bank_reset(d, s);
      end else begin
         pend_q <= trig;
         if (glob_we) glob_q[gidx] <= wdata;
         // corrected base lands one edge after the trigger
         for (int m = 0; m < NUM_MGD; m++) begin
            if (pend_q[m]) begin
               bank_q[mgd_dev(m)][SLOT_BHI] <= {4'h0, fix_i[m][11:8]};
               bank_q[mgd_dev(m)][SLOT_BLO] <= fix_i[m][7:0];
            end
         end
         // a fresh host write wins over a correction in the same cycle
         if (bank_we) bank_q[dev_i][slot] <= wdata;
      end
   end

   always_comb begin
      if (in_bank) begin
         if (!dev_ok)  rdata = 8'hFF;
         else if (hit) rdata = bank_q[dev_i][slot];
         else          rdata = 8'h00;
      end else begin
         rdata = g_ok ? glob_q[gidx] : 8'h00;
      end
   end

endmodule

// File: rtl/lcfg_ctl.sv
module lcfg_ctl
   import lcfg_pkg::*;
#(
   parameter int         NUM_DEV      = 10,
   parameter int         NUM_GLOBAL   = 48,
   parameter int         BANK_IDX     = 8'h30,
   parameter int         SEL_REG      = 7,
   parameter int         WR_LAST_DEV  = 5,
   parameter int         IRQ_FREE_DEV = 4,
   parameter logic [7:0] KEY_BYTE     = 8'h55,
   parameter logic [7:0] EXIT_BYTE    = 8'hAA,
   parameter bit         CHECK_ON_ACT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_wr,
   input  logic                       bus_addr,
   input  logic [7:0]                 bus_wdata,
   output logic [7:0]                 bus_rdata,
   output logic [NUM_MGD*BASE_W-1:0]  dev_base_o,
   output logic [NUM_MGD-1:0]         dev_act_o,
   output logic [NUM_MGD*IRQ_W-1:0]   dev_irq_o
);

   if (NUM_DEV < 8 || NUM_DEV > 16) begin : g_bad_dev
      $error("lcfg_ctl: NUM_DEV must lie in 8..16");
   end
   if (NUM_GLOBAL > BANK_IDX || SEL_REG >= NUM_GLOBAL) begin : g_bad_glob
      $error("lcfg_ctl: global window does not fit below the bank window");
   end
   if (WR_LAST_DEV >= NUM_DEV || WR_LAST_DEV < 5) begin : g_bad_wr
      $error("lcfg_ctl: WR_LAST_DEV must cover all managed devices");
   end

   logic                          unlocked;
   logic [7:0]                    ptr;
   logic [7:0]                    data_rd;
   logic [NUM_MGD-1:0]            fix_pend;
   logic [NUM_MGD-1:0][3:0]       raw_hi;
   logic [NUM_MGD-1:0][7:0]       raw_lo;
   logic [NUM_MGD-1:0][BASE_W-1:0] fixed;
   logic [NUM_MGD-1:0][IRQ_W-1:0]  irq;

   lcfg_gate #(
      .KEY_BYTE (KEY_BYTE),
      .EXIT_BYTE(EXIT_BYTE)
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .idx_wr(bus_wr && !bus_addr),
      .wdata (bus_wdata),
      .open_o(unlocked),
      .ptr_o (ptr)
   );

   lcfg_store #(
      .NUM_DEV     (NUM_DEV),
      .NUM_GLOBAL  (NUM_GLOBAL),
      .BANK_IDX    (BANK_IDX),
      .SEL_REG     (SEL_REG),
      .WR_LAST_DEV (WR_LAST_DEV),
      .IRQ_FREE_DEV(IRQ_FREE_DEV),
      .CHECK_ON_ACT(CHECK_ON_ACT)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_wr (bus_wr && bus_addr && unlocked),
      .wdata   (bus_wdata),
      .ptr     (ptr),
      .fix_i   (fixed),
      .rdata   (data_rd),
      .pend_o  (fix_pend),
      .raw_hi_o(raw_hi),
      .raw_lo_o(raw_lo),
      .act_o   (dev_act_o),
      .irq_o   (irq)
   );

   for (genvar m = 0; m < NUM_MGD; m++) begin : g_fix
      lcfg_base_fix #(.SEL(m)) u_fix (
         .hi_i  (raw_hi[m]),
         .lo_i  (raw_lo[m]),
         .base_o(fixed[m])
      );
      assign dev_base_o[m*BASE_W +: BASE_W] = {raw_hi[m], raw_lo[m]};
      assign dev_irq_o[m*IRQ_W +: IRQ_W]    = irq[m];
   end

   assign bus_rdata = !unlocked ? 8'hFF : (bus_addr ? data_rd : ptr);

endmodule

// File: rtl/lcfg_ctl_chk.sv
module lcfg_ctl_chk
   import lcfg_pkg::*;
#(
   parameter logic [7:0] KEY_BYTE     = 8'h55,
   parameter logic [7:0] EXIT_BYTE    = 8'hAA,
   parameter bit         CHECK_ON_ACT = 1'b1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_wr,
   input logic                      bus_addr,
   input logic [7:0]                bus_wdata,
   input logic                      open_i,
   input logic [NUM_MGD-1:0]        pend_i,
   input logic [NUM_MGD*BASE_W-1:0] dev_base_i,
   input logic [NUM_MGD-1:0]        dev_act_i
);

   // R2: the block opens only on an index write of the key byte
   assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_i) |-> $past(bus_wr && !bus_addr && bus_wdata == KEY_BYTE));

   // R2: a non-key index byte never opens the block
   assert_stray_byte_stays_sealed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_i && bus_wr && !bus_addr && bus_wdata != KEY_BYTE) |=> !open_i);

   // R2: while sealed with nothing pending, device outputs hold
   assert_sealed_outputs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_i && pend_i == '0) |=> ($stable(dev_base_i) && $stable(dev_act_i)));

   // R4: the exit byte seals the block
   assert_exit_seals_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (open_i && bus_wr && !bus_addr && bus_wdata == EXIT_BYTE) |=> !open_i);

   if (CHECK_ON_ACT) begin : g_legal
      for (genvar m = 0; m < NUM_MGD; m++) begin : g_m
         // R8: an enabled device with no correction pending shows a legal base
         assert_base_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_act_i[m] && !pend_i[m]) |-> base_ok(m, dev_base_i[m*BASE_W +: BASE_W]));
      end
   end

endmodule

bind lcfg_ctl lcfg_ctl_chk #(
   .KEY_BYTE    (KEY_BYTE),
   .EXIT_BYTE   (EXIT_BYTE),
   .CHECK_ON_ACT(CHECK_ON_ACT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .open_i    (unlocked),
   .pend_i    (fix_pend),
   .dev_base_i(dev_base_o),
   .dev_act_i (dev_act_o)
);

// File: tb/lcfg_ctl_bench.sv
`timescale 1ns/1ps
module lcfg_ctl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_addr = 1'b0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic [47:0] dev_base_o;
   logic [3:0]  dev_act_o;
   logic [15:0] dev_irq_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   lcfg_ctl u_lcfg_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .dev_base_o(dev_base_o),
      .dev_act_o (dev_act_o),
      .dev_irq_o (dev_irq_o)
   );

   function automatic logic [11:0] base_of(input int m);
      return dev_base_o[m*12 +: 12];
   endfunction

   function automatic logic [3:0] irq_of(input int m);
      return dev_irq_o[m*4 +: 4];
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic port, input logic [7:0] v);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = port; bus_wdata = v;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic port, output logic [7:0] v);
      bus_addr = port;
      #1;
      v = bus_rdata;
   endtask

   task automatic put(input logic [7:0] idx, input logic [7:0] v);
      bus_write(1'b0, idx);
      bus_write(1'b1, v);
   endtask

   task automatic get(input logic [7:0] idx, output logic [7:0] v);
      bus_write(1'b0, idx);
      bus_read(1'b1, v);
   endtask

   task automatic settle();
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      bus_read(1'b0, v); check("R3", "sealed index read", 16'(v), 16'h00FF);
      bus_read(1'b1, v); check("R3", "sealed data read", 16'(v), 16'h00FF);
      check("R1", "base slot0", 16'(base_of(0)), 16'h03F0);
      check("R1", "base slot1", 16'(base_of(1)), 16'h0378);
      check("R1", "base slot2", 16'(base_of(2)), 16'h03F8);
      check("R1", "base slot3", 16'(base_of(3)), 16'h02F8);
      check("R1", "enables", 16'(dev_act_o), 16'h000F);
      check("R1", "irqs", dev_irq_o, 16'h3476);
   endtask

   task automatic t_unlock();
      logic [7:0] v;
      bus_write(1'b1, 8'h77);           // sealed data write, must be dropped
      bus_write(1'b0, 8'h55);
      bus_write(1'b0, 8'h12);
      bus_write(1'b0, 8'h55);
      bus_read(1'b0, v); check("R2", "broken key keeps seal", 16'(v), 16'h00FF);
      bus_write(1'b0, 8'h55);
      bus_read(1'b0, v); check("R4", "pointer after open", 16'(v), 16'h0000);
      bus_read(1'b1, v); check("R2", "sealed data write dropped", 16'(v), 16'h0000);
   endtask

   task automatic t_global();
      logic [7:0] v;
      get(8'h03, v); check("R1", "global 03", 16'(v), 16'h0003);
      get(8'h20, v); check("R1", "global 20", 16'(v), 16'h0003);
      get(8'h21, v); check("R1", "global 21", 16'(v), 16'h0001);
      get(8'h24, v); check("R1", "global 24", 16'(v), 16'h0004);
      get(8'h26, v); check("R1", "global 26", 16'(v), 16'h00F0);
      get(8'h27, v); check("R1", "global 27", 16'(v), 16'h0003);
      put(8'h10, 8'h5A);
      get(8'h10, v); check("R5", "global 10 rw", 16'(v), 16'h005A);
      put(8'h2F, 8'hC3);
      get(8'h2F, v); check("R5", "last global rw", 16'(v), 16'h00C3);
      bus_read(1'b0, v); check("R4", "index reads pointer", 16'(v), 16'h002F);
   endtask

   task automatic t_serial();
      logic [7:0] v;
      put(8'h07, 8'h04);
      get(8'h60, v); check("R6", "dev4 60", 16'(v), 16'h0003);
      get(8'h61, v); check("R6", "dev4 61", 16'(v), 16'h00F8);
      get(8'h70, v); check("R6", "dev4 70", 16'(v), 16'h0004);
      put(8'h61, 8'hE8); settle();
      check("R9", "dev4 legal 3E8", 16'(base_of(2)), 16'h03E8);
      put(8'h61, 8'h00);
      #1 check("R11", "raw base at store edge", 16'(base_of(2)), 16'h0300);
      @(negedge clk);
      #1 check("R8", "illegal -> default", 16'(base_of(2)), 16'h03F8);
      get(8'h61, v); check("R8", "default written back", 16'(v), 16'h00F8);
      put(8'h61, 8'hEF); settle();
      check("R8", "low bits masked", 16'(base_of(2)), 16'h03E8);
      get(8'h61, v); check("R8", "masked written back", 16'(v), 16'h00E8);
      put(8'h60, 8'h13); settle();
      get(8'h60, v); check("R8", "upper nibble cleared", 16'(v), 16'h0003);
      put(8'h70, 8'h05);
      #1 check("R11", "irq at store edge", 16'(irq_of(2)), 16'h0005);
      put(8'h40, 8'h99);
      get(8'h40, v); check("R6", "unimplemented bank index", 16'(v), 16'h0000);
   endtask

   task automatic t_floppy();
      logic [7:0] v;
      put(8'h07, 8'h00);
      put(8'h70, 8'h09);
      get(8'h70, v); check("R7", "dev0 70 write ignored", 16'(v), 16'h0006);
      check("R7", "dev0 irq unchanged", 16'(irq_of(0)), 16'h0006);
      put(8'h61, 8'h70); settle();
      check("R9", "dev0 legal 370", 16'(base_of(0)), 16'h0370);
      put(8'h60, 8'h02); settle();
      check("R9", "dev0 270 -> 3F0", 16'(base_of(0)), 16'h03F0);
      get(8'h60, v); check("R8", "dev0 60 written back", 16'(v), 16'h0003);
   endtask

   task automatic t_parallel();
      put(8'h07, 8'h03);
      put(8'h60, 8'h02); settle();
      check("R9", "dev3 legal 278", 16'(base_of(1)), 16'h0278);
      put(8'h60, 8'h03); settle();
      put(8'h61, 8'hBC); settle();
      check("R9", "dev3 3BC masked -> 378", 16'(base_of(1)), 16'h0378);
   endtask

   task automatic t_activate();
      logic [7:0] v;
      put(8'h07, 8'h05);
      put(8'h30, 8'h00); settle();
      check("R10", "dev5 disabled", 16'(dev_act_o), 16'h0007);
      put(8'h61, 8'h00); settle();
      check("R10", "disabled base unchecked", 16'(base_of(3)), 16'h0200);
      get(8'h61, v); check("R10", "raw 61 stored", 16'(v), 16'h0000);
      put(8'h30, 8'h01); settle();
      check("R10", "dev5 enabled", 16'(dev_act_o), 16'h000F);
      check("R10", "enable runs check", 16'(base_of(3)), 16'h02F8);
   endtask

   task automatic t_blocked();
      logic [7:0] v;
      put(8'h07, 8'h06);
      put(8'h63, 8'h55);
      get(8'h63, v); check("R7", "dev6 write ignored", 16'(v), 16'h0070);
      put(8'h07, 8'h07);
      put(8'h30, 8'h00);
      get(8'h30, v); check("R7", "dev7 write ignored", 16'(v), 16'h0001);
      put(8'h07, 8'h0C);
      get(8'h30, v); check("R6", "device 12 reads FF", 16'(v), 16'h00FF);
   endtask

   task automatic t_lock();
      logic [7:0] v;
      bus_write(1'b0, 8'hAA);
      bus_read(1'b0, v); check("R4", "exit seals index", 16'(v), 16'h00FF);
      bus_read(1'b1, v); check("R3", "exit seals data", 16'(v), 16'h00FF);
      bus_write(1'b1, 8'h00); settle();
      check("R2", "outputs kept while sealed", 16'(base_of(3)), 16'h02F8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unlock();
      t_global();
      t_serial();
      t_floppy();
      t_parallel();
      t_activate();
      t_blocked();
      t_lock();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule